// File: doc/BRIEF.md
# Concurrent-Write Conflict Resolver

This block guards one shared memory word that many processing elements can reach in the same cycle. Every lane presents a valid bit and a data word, and the lane's position on the bus is its identifier. A policy input selects how simultaneous writes are settled. Exclusive mode flags any collision. Priority, arbitrary and random modes pick one lane. Common mode stores a value only when all writers agree. Combining mode reduces every active value to one word with a selectable arithmetic or Boolean operator. The block produces a write enable, the resolved word and an error flag, all registered one cycle after the request.

The same block also settles reads of the word. In shared-read mode every reader is granted and receives the stored word. In single-reader mode a second simultaneous reader is an error and no reader is granted. The storage word sits outside the block. The resolver drives its write port and samples its output for readers.

Top module: `cwr_resolver`

## Requirements
- R1: With policy code 0 (exclusive), exactly one valid lane writes its word with no error; two or more valid lanes raise `wr_err` and keep `wr_en` low.
- R2: With policy code 1 (priority), the valid lane with the highest index writes its word.
- R3: With policy code 2 (common), the word is written only when every valid lane carries the same value; otherwise `wr_en` stays low and `wr_err` rises.
- R4: With policy code 3 (arbitrary), the valid lane with the lowest index writes its word.
- R5: With policy code 4 (random), exactly one valid lane's word is written with no error. The lane is found by a scan that starts at a position taken from a 16-bit maximal-length LFSR with a nonzero seed and rotates upward from there.
- R6: With policy code 5 (combine), op code 0 writes the sum and op code 1 writes the product of all valid words, both modulo 2^W.
- R7: With policy code 5, op code 2 writes the unsigned maximum and op code 3 writes the unsigned minimum of the valid words.
- R8: With policy code 5, op codes 4, 5 and 6 write the bitwise AND, OR and XOR of the valid words.
- R9: With no valid lane, `wr_en` and `wr_err` stay low under every policy, and the stored word is unchanged.
- R10: Every output is registered: results appear one clock after the request. After reset all outputs are zero, and `wr_en` and `wr_err` are never high together.
- R11: With `rd_shared` low, a single reader is granted and gets the stored word. Two or more readers raise `rd_err`, grant no lane and return zero.
- R12: With `rd_shared` high, every requesting reader is granted, `rd_err` stays low and `rd_data` is the stored word.
- R13: Policy codes 6 and 7, and op code 7 under policy 5, raise `wr_err` and perform no write when any lane is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPE | Write request per lane |
| req_data | input | NPE*W | Write words; lane k at bits k*W +: W |
| policy | input | 3 | Write policy code |
| comb_op | input | 3 | Reduction operator for combine mode |
| rd_valid | input | NPE | Read request per lane |
| rd_shared | input | 1 | 1 = shared reads, 0 = single reader |
| mem_q | input | W | Current stored word |
| wr_en | output | 1 | Write enable to the storage word |
| wr_data | output | W | Resolved word to store |
| wr_err | output | 1 | Write conflict or illegal code |
| rd_grant | output | NPE | Lanes whose read was granted |
| rd_data | output | W | Stored word returned to readers |
| rd_err | output | 1 | Read collision in single-reader mode |

## Verification
The same request set, lanes 1 and 2 with different words, is sent under priority and under arbitrary policy, so a swapped index order shows up as the wrong winner. Common mode gets an agreeing set and a disagreeing set. The reductions use operands that cross the word width (200+100, 16*32) and that straddle the sign bit (0x80 against 0x7F), so a signed compare or a widened result stands out. Random mode is checked by membership in the active set, over many cycles and sparse patterns. Idle cycles and reads from the bench's storage word confirm that the stored word is left unchanged.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  typedef enum logic [2:0] {
    POL_EXCL   = 3'd0,
    POL_PRIO   = 3'd1,
    POL_COMMON = 3'd2,
    POL_ARB    = 3'd3,
    POL_RAND   = 3'd4,
    POL_COMB   = 3'd5
  } policy_e;

  typedef enum logic [2:0] {
    OP_SUM  = 3'd0,
    OP_PROD = 3'd1,
    OP_MAX  = 3'd2,
    OP_MIN  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6
  } comb_op_e;

  localparam logic [15:0] LFSR_TAPS = 16'hB400;
endpackage

// File: rtl/cwr_lfsr.sv
module cwr_lfsr #(
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic        clk,
  input  logic        rst,
  output logic [15:0] state
);
  import cwr_pkg::*;
  logic [15:0] st_q;

  always_ff @(posedge clk) begin
    if (rst) st_q <= (SEED == 16'd0) ? 16'd1 : SEED;
    else if (st_q[0]) st_q <= (st_q >> 1) ^ LFSR_TAPS;
    else st_q <= st_q >> 1;
  end

  assign state = st_q;
endmodule

// File: rtl/cwr_pick.sv
module cwr_pick #(
  parameter int NPE = 4,
  localparam int IW = (NPE > 1) ? $clog2(NPE) : 1
) (
  input  logic [NPE-1:0] valid,
  input  logic [IW-1:0]  start,
  output logic [IW-1:0]  lo_idx,
  output logic [IW-1:0]  hi_idx,
  output logic [IW-1:0]  rot_idx
);
  always_comb begin
    lo_idx = '0;
    hi_idx = '0;
    rot_idx = '0;
    for (int k = NPE - 1; k >= 0; k--)
      if (valid[k]) lo_idx = IW'(k);
    for (int k = 0; k < NPE; k++)
      if (valid[k]) hi_idx = IW'(k);
    for (int k = NPE - 1; k >= 0; k--) begin
      int j;
      j = (int'(start) + k) % NPE;
      if (valid[j]) rot_idx = IW'(j);
    end
  end
endmodule

// File: rtl/cwr_combine.sv
module cwr_combine #(
  parameter int NPE = 4,
  parameter int W   = 8
) (
  input  logic [NPE-1:0]   valid,
  input  logic [NPE*W-1:0] data,
  input  logic [2:0]       op,
  output logic [W-1:0]     result,
  output logic             bad_op
);
  import cwr_pkg::*;
  comb_op_e opc;
  assign opc = comb_op_e'(op);

  always_comb begin
    logic [W-1:0] d;
    bad_op = 1'b0;
    case (opc)
      OP_PROD, OP_AND, OP_MIN: result = '1;
      default:                 result = '0;
    endcase
    if (opc == OP_PROD) result = W'(1);
    for (int k = 0; k < NPE; k++) begin
      d = data[k*W +: W];
      if (valid[k]) begin
        case (opc)
          OP_SUM:  result = result + d;
          OP_PROD: result = result * d;
          OP_MAX:  result = (d > result) ? d : result;
          OP_MIN:  result = (d < result) ? d : result;
          OP_AND:  result = result & d;
          OP_OR:   result = result | d;
          OP_XOR:  result = result ^ d;
          default: bad_op = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/cwr_resolver.sv
module cwr_resolver #(
  parameter int          NPE  = 4,
  parameter int          W    = 8,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPE-1:0]   req_valid,
  input  logic [NPE*W-1:0] req_data,
  input  logic [2:0]       policy,
  input  logic [2:0]       comb_op,
  input  logic [NPE-1:0]   rd_valid,
  input  logic             rd_shared,
  input  logic [W-1:0]     mem_q,
  output logic             wr_en,
  output logic [W-1:0]     wr_data,
  output logic             wr_err,
  output logic [NPE-1:0]   rd_grant,
  output logic [W-1:0]     rd_data,
  output logic             rd_err
);
  import cwr_pkg::*;
  localparam int IW = (NPE > 1) ? $clog2(NPE) : 1;

  logic [15:0]  lfsr;
  logic [IW-1:0] start, lo_idx, hi_idx, rot_idx;
  logic [W-1:0] comb_res;
  logic         bad_op;

  cwr_lfsr #(.SEED(SEED)) u_lfsr (.clk(clk), .rst(rst), .state(lfsr));

  assign start = IW'(lfsr % NPE);

  cwr_pick #(.NPE(NPE)) u_pick (
    .valid(req_valid), .start(start),
    .lo_idx(lo_idx), .hi_idx(hi_idx), .rot_idx(rot_idx)
  );

  cwr_combine #(.NPE(NPE), .W(W)) u_comb (
    .valid(req_valid), .data(req_data), .op(comb_op),
    .result(comb_res), .bad_op(bad_op)
  );

  logic         any_wr, multi_wr, agree;
  logic         en_d, err_d;
  logic [W-1:0] data_d;
  logic         multi_rd;

  always_comb begin
    agree = 1'b1;
    for (int k = 0; k < NPE; k++)
      if (req_valid[k] && req_data[k*W +: W] != req_data[int'(lo_idx)*W +: W])
        agree = 1'b0;
  end

  assign any_wr   = |req_valid;
  assign multi_wr = $countones(req_valid) > 1;
  assign multi_rd = $countones(rd_valid) > 1;

  always_comb begin
    en_d   = 1'b0;
    err_d  = 1'b0;
    data_d = '0;
    if (any_wr) begin
      case (policy_e'(policy))
        POL_EXCL: begin
          en_d   = !multi_wr;
          err_d  = multi_wr;
          data_d = multi_wr ? '0 : req_data[int'(lo_idx)*W +: W];
        end
        POL_PRIO: begin
          en_d   = 1'b1;
          data_d = req_data[int'(hi_idx)*W +: W];
        end
        POL_COMMON: begin
          en_d   = agree;
          err_d  = !agree;
          data_d = agree ? req_data[int'(lo_idx)*W +: W] : '0;
        end
        POL_ARB: begin
          en_d   = 1'b1;
          data_d = req_data[int'(lo_idx)*W +: W];
        end
        POL_RAND: begin
          en_d   = 1'b1;
          data_d = req_data[int'(rot_idx)*W +: W];
        end
        POL_COMB: begin
          en_d   = !bad_op;
          err_d  = bad_op;
          data_d = bad_op ? '0 : comb_res;
        end
        default: err_d = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en    <= 1'b0;
      wr_err   <= 1'b0;
      wr_data  <= '0;
      rd_grant <= '0;
      rd_data  <= '0;
      rd_err   <= 1'b0;
    end else begin
      wr_en   <= en_d;
      wr_err  <= err_d;
      wr_data <= data_d;
      if (!rd_shared && multi_rd) begin
        rd_grant <= '0;
        rd_data  <= '0;
        rd_err   <= 1'b1;
      end else begin
        rd_grant <= rd_valid;
        rd_data  <= (|rd_valid) ? mem_q : '0;
        rd_err   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cwr_resolver_chk.sv
module cwr_resolver_chk #(
  parameter int NPE = 4,
  parameter int W   = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPE-1:0]   req_valid,
  input logic [2:0]       policy,
  input logic [NPE-1:0]   rd_valid,
  input logic             rd_shared,
  input logic             wr_en,
  input logic             wr_err,
  input logic [NPE-1:0]   rd_grant,
  input logic             rd_err
);
  assert_excl_collide_R1: assert property (@(posedge clk) disable iff (rst)
    (policy == 3'd0 && $countones(req_valid) > 1) |=> (wr_err && !wr_en));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid == '0) |=> (!wr_en && !wr_err));

  assert_en_err_apart_R10: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !wr_err);

  assert_single_reader_R11: assert property (@(posedge clk) disable iff (rst)
    (!rd_shared && $countones(rd_valid) > 1) |=> (rd_err && rd_grant == '0));

  assert_shared_read_R12: assert property (@(posedge clk) disable iff (rst)
    rd_shared |=> (!rd_err && rd_grant == $past(rd_valid)));

  assert_reserved_policy_R13: assert property (@(posedge clk) disable iff (rst)
    (policy > 3'd5 && req_valid != '0) |=> (wr_err && !wr_en));
endmodule

bind cwr_resolver cwr_resolver_chk #(.NPE(NPE), .W(W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .policy(policy),
  .rd_valid(rd_valid), .rd_shared(rd_shared), .wr_en(wr_en),
  .wr_err(wr_err), .rd_grant(rd_grant), .rd_err(rd_err)
);

// File: tb/cwr_resolver_tb.sv
module cwr_resolver_tb;
  localparam int NPE = 4;
  localparam int W   = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [NPE-1:0]   req_valid = '0;
  logic [NPE*W-1:0] req_data = '0;
  logic [2:0]       policy = '0;
  logic [2:0]       comb_op = '0;
  logic [NPE-1:0]   rd_valid = '0;
  logic             rd_shared = 1'b0;
  logic [W-1:0]     mem;
  logic             wr_en, wr_err, rd_err;
  logic [W-1:0]     wr_data, rd_data;
  logic [NPE-1:0]   rd_grant;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  cwr_resolver #(.NPE(NPE), .W(W)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_data(req_data),
    .policy(policy), .comb_op(comb_op), .rd_valid(rd_valid),
    .rd_shared(rd_shared), .mem_q(mem), .wr_en(wr_en), .wr_data(wr_data),
    .wr_err(wr_err), .rd_grant(rd_grant), .rd_data(rd_data), .rd_err(rd_err)
  );

  // behavioural storage word
  always_ff @(posedge clk) begin
    if (rst) mem <= 8'h5A;
    else if (wr_en) mem <= wr_data;
  end

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int             due;
    string          req;
    bit             any_of;   // data must be one of the active words
    logic [NPE-1:0] act;
    logic [NPE*W-1:0] words;
    logic           en;
    logic [W-1:0]   data;
    logic           err;
    bit             chk_rd;
    logic [NPE-1:0] gnt;
    logic [W-1:0]   rdat;
    logic           rerr;
  } exp_t;

  exp_t sb[$];

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // driver: apply one request cycle and queue the expected result
  task automatic drive(input string req, input logic [2:0] pol, input logic [2:0] op,
                       input logic [NPE-1:0] v, input logic [NPE*W-1:0] d,
                       input logic en, input logic [W-1:0] data, input logic err,
                       input bit any_of = 0, input bit chk_rd = 0,
                       input logic [NPE-1:0] rv = '0, input logic sh = 1'b0,
                       input logic [NPE-1:0] gnt = '0, input logic [W-1:0] rdat = '0,
                       input logic rerr = 1'b0);
    exp_t e;
    @(posedge clk);
    #2;
    policy = pol; comb_op = op; req_valid = v; req_data = d;
    rd_valid = rv; rd_shared = sh;
    e.due = cyc + 1; e.req = req; e.any_of = any_of; e.act = v; e.words = d;
    e.en = en; e.data = data; e.err = err; e.chk_rd = chk_rd;
    e.gnt = gnt; e.rdat = rdat; e.rerr = rerr;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk);
      #2;
      req_valid = '0; rd_valid = '0;
    end
  endtask

  // monitor: compare results one clock after each request
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      check(e.req, "wr_en", 32'(wr_en), 32'(e.en));
      check(e.req, "wr_err", 32'(wr_err), 32'(e.err));
      if (e.any_of) begin
        bit hit = 0;
        for (int k = 0; k < NPE; k++)
          if (e.act[k] && e.words[k*W +: W] == wr_data) hit = 1;
        check(e.req, "random word in active set", 32'(hit), 32'd1);
      end else if (e.en) begin
        check(e.req, "wr_data", 32'(wr_data), 32'(e.data));
      end
      if (e.chk_rd) begin
        check(e.req, "rd_grant", 32'(rd_grant), 32'(e.gnt));
        check(e.req, "rd_data", 32'(rd_data), 32'(e.rdat));
        check(e.req, "rd_err", 32'(rd_err), 32'(e.rerr));
      end
    end
  end

  function automatic logic [NPE*W-1:0] pk(input logic [W-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [W-1:0] keep;
    repeat (3) @(posedge clk);
    #2;
    // R10: reset state
    check("R10", "wr_en after reset", 32'(wr_en), 32'd0);
    check("R10", "wr_data after reset", 32'(wr_data), 32'd0);
    check("R10", "rd_grant after reset", 32'(rd_grant), 32'd0);
    rst = 1'b0;

    // R1 exclusive
    drive("R1", 3'd0, 3'd0, 4'b0100, pk(8'h11, 8'h22, 8'h33, 8'h44), 1, 8'h33, 0);
    drive("R1", 3'd0, 3'd0, 4'b0110, pk(8'h11, 8'h22, 8'h33, 8'h44), 0, 8'h00, 1);
    // R2 / R4 same set, different winners
    drive("R2", 3'd1, 3'd0, 4'b0110, pk(8'h11, 8'h22, 8'h33, 8'h44), 1, 8'h33, 0);
    drive("R4", 3'd3, 3'd0, 4'b0110, pk(8'h11, 8'h22, 8'h33, 8'h44), 1, 8'h22, 0);
    drive("R2", 3'd1, 3'd0, 4'b1001, pk(8'h11, 8'h22, 8'h33, 8'h44), 1, 8'h44, 0);
    drive("R4", 3'd3, 3'd0, 4'b1001, pk(8'h11, 8'h22, 8'h33, 8'h44), 1, 8'h11, 0);
    // R3 common
    drive("R3", 3'd2, 3'd0, 4'b1011, pk(8'h77, 8'h77, 8'h01, 8'h77), 1, 8'h77, 0);
    drive("R3", 3'd2, 3'd0, 4'b0011, pk(8'h77, 8'h76, 8'h01, 8'h77), 0, 8'h00, 1);
    // R6 sum/product wrap
    drive("R6", 3'd5, 3'd0, 4'b0011, pk(8'd200, 8'd100, 8'd9, 8'd9), 1, 8'd44, 0);
    drive("R6", 3'd5, 3'd1, 4'b0011, pk(8'd16, 8'd32, 8'd9, 8'd9), 1, 8'd0, 0);
    drive("R6", 3'd5, 3'd1, 4'b0111, pk(8'd3, 8'd5, 8'd7, 8'd9), 1, 8'd105, 0);
    // R7 unsigned max/min
    drive("R7", 3'd5, 3'd2, 4'b0101, pk(8'h80, 8'hFF, 8'h7F, 8'h00), 1, 8'h80, 0);
    drive("R7", 3'd5, 3'd3, 4'b0101, pk(8'h80, 8'hFF, 8'h7F, 8'h00), 1, 8'h7F, 0);
    // R8 boolean
    drive("R8", 3'd5, 3'd4, 4'b0111, pk(8'hF3, 8'h3F, 8'h7E, 8'h00), 1, 8'h32, 0);
    drive("R8", 3'd5, 3'd5, 4'b0111, pk(8'h01, 8'h02, 8'h40, 8'hFF), 1, 8'h43, 0);
    drive("R8", 3'd5, 3'd6, 4'b0111, pk(8'hF0, 8'h0F, 8'h33, 8'hFF), 1, 8'hCC, 0);
    // R13 reserved codes
    drive("R13", 3'd6, 3'd0, 4'b0001, pk(8'h11, 8'h22, 8'h33, 8'h44), 0, 8'h00, 1);
    drive("R13", 3'd5, 3'd7, 4'b0011, pk(8'h11, 8'h22, 8'h33, 8'h44), 0, 8'h00, 1);
    // R5 random
    for (int r = 0; r < 24; r++) begin
      logic [NPE-1:0] v;
      v = 4'(r % 15 + 1);
      drive("R5", 3'd4, 3'd0, v, pk(8'hA0, 8'hB1, 8'hC2, 8'hD3), 1, 8'h00, 0, 1);
    end
    drive("R5", 3'd4, 3'd0, 4'b1000, pk(8'hA0, 8'hB1, 8'hC2, 8'hD3), 1, 8'hD3, 0);
    idle(3);

    // R9 idle under every policy leaves the word untouched
    keep = mem;
    for (int p = 0; p < 8; p++)
      drive("R9", 3'(p), 3'd0, 4'b0000, pk(8'hEE, 8'hEE, 8'hEE, 8'hEE), 0, 8'h00, 0);
    idle(3);
    check("R9", "stored word unchanged", 32'(mem), 32'(keep));

    // R11 single-reader mode
    drive("R11", 3'd0, 3'd0, 4'b0000, '0, 0, 8'h00, 0, 0, 1, 4'b0010, 1'b0, 4'b0010, keep, 0);
    drive("R11", 3'd0, 3'd0, 4'b0000, '0, 0, 8'h00, 0, 0, 1, 4'b0110, 1'b0, 4'b0000, 8'h00, 1);
    // R12 shared reads
    drive("R12", 3'd0, 3'd0, 4'b0000, '0, 0, 8'h00, 0, 0, 1, 4'b1111, 1'b1, 4'b1111, keep, 0);
    drive("R12", 3'd0, 3'd0, 4'b0000, '0, 0, 8'h00, 0, 0, 1, 4'b1010, 1'b1, 4'b1010, keep, 0);
    idle(3);
    // R12: read sees a word written just before
    drive("R12", 3'd3, 3'd0, 4'b0001, pk(8'h3C, 8'h00, 8'h00, 8'h00), 1, 8'h3C, 0);
    idle(2);
    drive("R12", 3'd0, 3'd0, 4'b0000, '0, 0, 8'h00, 0, 0, 1, 4'b0101, 1'b1, 4'b0101, 8'h3C, 0);
    idle(4);
    if (sb.size() != 0) begin
      n_run++; n_fail++;
      $display("FAIL R10: actual %0d pending results expected 0", sb.size());
    end
    finish_run();
  end
endmodule